// File: doc/BRIEF.md
# Dual Reloading Interval Timer

This block holds two independent down-counters that advance on a shared periodic tick strobe, and each raises its own interrupt line. The tick comes from a prescaler outside the block. A small register bus with an enable, a write flag, an address and a data word gives access to four registers.

The gated counter ("A") holds a start value and a current count. It moves only while an enable-mask register permits it. Touching its status register does three things: it returns the count, it drops the interrupt, and it reloads the count from the start value.

The periodic counter ("B") runs freely whenever its period register is nonzero. Each time it falls below one it reloads itself and raises its interrupt. A dedicated acknowledge input clears that interrupt.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both interrupt outputs are low and all four registers read back as zero; `rdata` is zero whenever no read is in progress.
- R2: A write to address 0 (reload) sets both the start value and the current count of counter A, and takes precedence over a tick in the same cycle. A read of address 0 returns the start value.
- R3: On a tick, counter A decreases by 2 only when three conditions hold: the start value is nonzero, the current count is greater than zero, and bit 1 of the mask register is set. Otherwise the count holds.
- R4: When a decrement of counter A produces a count of zero or less (signed), `irq_a` is set in the same edge.
- R5: Any access to address 1 (status), read or write, clears `irq_a` and loads counter A's count from the start value, and a tick in that cycle has no effect on counter A. A read of address 1 returns the count as it was before the access.
- R6: A write to address 2 (mask) stores the whole data word, and a read of address 2 returns it.
- R7: A write to address 3 (period) stores the period and also loads counter B's count with it. A read returns the period. While the period is nonzero, each tick lowers counter B by 5.
- R8: When a tick would bring counter B below 1 (signed), the count instead reloads from the period and `irq_b` is set.
- R9: `ack_b` clears `irq_b`. When a reload event of counter B falls in the same cycle as `ack_b`, `irq_b` stays set.
- R10: A write to address 3 in a tick cycle takes precedence over that tick for counter B: the count becomes the written value and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Periodic advance strobe, one cycle wide |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register select: 0 reload, 1 status, 2 mask, 3 period |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, zero when idle |
| ack_b | input | 1 | Clears counter B's interrupt |
| irq_a | output | 1 | Counter A interrupt |
| irq_b | output | 1 | Counter B interrupt |

## Verification
The assertions assume that `tick`, `bus_en` and `ack_b` are clean single-cycle levels that are sampled at the rising edge. They also assume that the written counts are far enough from the signed minimum that subtracting a step cannot wrap. The stimulus keeps every loaded value in a small signed range (about -8 to 40), so wraparound never happens. Ticks, accesses and acknowledges are drawn freely, and they often collide in the same cycle, because the precedence rules are defined for exactly those cases.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   typedef enum logic [1:0] {
      SEL_RELOAD = 2'd0,
      SEL_STATUS = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_PERIOD = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/itmr_bus_if.sv
module itmr_bus_if
   import itmr_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] start_a,
   input  logic [DATA_W-1:0] count_a,
   input  logic [DATA_W-1:0] period_b,
   output logic              wr_reload,
   output logic              acc_status,
   output logic              wr_period,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int HI_W = ADDR_W - 2;

   logic     hit;
   reg_sel_e sel;

   assign sel = reg_sel_e'(bus_addr[1:0]);

   generate
      if (HI_W > 0) begin : g_hi
         assign hit = bus_en && (bus_addr[ADDR_W-1:2] == '0);
      end else begin : g_nohi
         assign hit = bus_en;
      end
   endgenerate

   assign wr_reload  = hit && bus_we && (sel == SEL_RELOAD);
   assign acc_status = hit && (sel == SEL_STATUS);
   assign wr_period  = hit && bus_we && (sel == SEL_PERIOD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (hit && bus_we && (sel == SEL_MASK))
         mask_q <= bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (hit && !bus_we) begin
         unique case (sel)
            SEL_RELOAD: bus_rdata = start_a;
            SEL_STATUS: bus_rdata = count_a;
            SEL_MASK:   bus_rdata = mask_q;
            SEL_PERIOD: bus_rdata = period_b;
            default:    bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/itmr_gated_cnt.sv
module itmr_gated_cnt #(
   parameter int DATA_W = 32,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              gate,
   input  logic              wr_reload,
   input  logic              acc_status,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] start_q,
   output logic [DATA_W-1:0] count_q,
   output logic              irq
);
   localparam logic signed [DATA_W-1:0] STEP_S = DATA_W'(STEP);

   logic signed [DATA_W-1:0] cnt_s;
   logic signed [DATA_W-1:0] next_s;
   logic                     run;

   assign cnt_s  = $signed(count_q);
   assign next_s = cnt_s - STEP_S;
   assign run    = tick && gate && (start_q != '0) && (cnt_s > 0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         count_q <= '0;
         irq     <= 1'b0;
      end else if (wr_reload) begin
         start_q <= wdata;
         count_q <= wdata;
      end else if (acc_status) begin
         count_q <= start_q;
         irq     <= 1'b0;
      end else if (run) begin
         count_q <= next_s;
         if (next_s <= 0)
            irq <= 1'b1;
      end
   end
endmodule

// File: rtl/itmr_period_cnt.sv
module itmr_period_cnt #(
   parameter int DATA_W       = 32,
   parameter int STEP         = 5,
   parameter bit SET_OVER_ACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_period,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   output logic [DATA_W-1:0] period_q,
   output logic              irq
);
   localparam logic signed [DATA_W-1:0] STEP_S = DATA_W'(STEP);

   logic [DATA_W-1:0]        count_q;
   logic signed [DATA_W-1:0] next_s;
   logic                     run;
   logic                     wrap;

   assign next_s = $signed(count_q) - STEP_S;
   assign run    = tick && !wr_period && (period_q != '0);
   assign wrap   = run && (next_s < 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         count_q  <= '0;
      end else if (wr_period) begin
         period_q <= wdata;
         count_q  <= wdata;
      end else if (wrap) begin
         count_q <= period_q;
      end else if (run) begin
         count_q <= next_s;
      end
   end

   generate
      if (SET_OVER_ACK) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    irq <= 1'b0;
            else if (wrap) irq <= 1'b1;
            else if (ack)  irq <= 1'b0;
         end
      end else begin : g_ack_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    irq <= 1'b0;
            else if (ack)  irq <= 1'b0;
            else if (wrap) irq <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
   parameter int ADDR_W       = 4,
   parameter int DATA_W       = 32,
   parameter int STEP_A       = 2,
   parameter int STEP_B       = 5,
   parameter int GATE_BIT     = 1,
   parameter bit SET_OVER_ACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ack_b,
   output logic              irq_a,
   output logic              irq_b
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (STEP_A < 1 || STEP_B < 1) begin : g_bad_step
         $error("step sizes must be positive");
      end
      if (GATE_BIT < 0 || GATE_BIT >= DATA_W) begin : g_bad_gate
         $error("GATE_BIT outside the mask word");
      end
   endgenerate

   logic              wr_reload;
   logic              acc_status;
   logic              wr_period;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] start_a;
   logic [DATA_W-1:0] count_a;
   logic [DATA_W-1:0] period_b;
   logic              gate_a;

   assign gate_a = mask_q[GATE_BIT];

   itmr_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_en     (bus_en),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .start_a    (start_a),
      .count_a    (count_a),
      .period_b   (period_b),
      .wr_reload  (wr_reload),
      .acc_status (acc_status),
      .wr_period  (wr_period),
      .mask_q     (mask_q),
      .bus_rdata  (bus_rdata)
   );

   itmr_gated_cnt #(.DATA_W(DATA_W), .STEP(STEP_A)) u_cnt_a (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .gate       (gate_a),
      .wr_reload  (wr_reload),
      .acc_status (acc_status),
      .wdata      (bus_wdata),
      .start_q    (start_a),
      .count_q    (count_a),
      .irq        (irq_a)
   );

   itmr_period_cnt #(.DATA_W(DATA_W), .STEP(STEP_B), .SET_OVER_ACK(SET_OVER_ACK)) u_cnt_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr_period (wr_period),
      .wdata     (bus_wdata),
      .ack       (ack_b),
      .period_q  (period_b),
      .irq       (irq_b)
   );
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_en,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              ack_b,
   input logic              gate_a,
   input logic              irq_a,
   input logic              irq_b
);
   logic status_hit;
   logic period_wr;
   assign status_hit = bus_en && (bus_addr == ADDR_W'(1));
   assign period_wr  = bus_en && bus_we && (bus_addr == ADDR_W'(3));

   AST_IRQA_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      status_hit |=> !irq_a); // R5

   AST_IRQA_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_a) |-> $past(tick)); // R4

   AST_IRQA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_a) |-> $past(gate_a)); // R3

   AST_IRQB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_b) |-> $past(tick)); // R8

   AST_IRQB_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_b && !tick) |=> !irq_b); // R9

   AST_PERIOD_WR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (period_wr && !irq_b) |=> !irq_b); // R10
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .bus_en   (bus_en),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .ack_b    (ack_b),
   .gate_a   (gate_a),
   .irq_a    (irq_a),
   .irq_b    (irq_b)
);

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
   localparam int AW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          bus_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          ack_b = 1'b0;
   logic          irq_a;
   logic          irq_b;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   // reference state
   int m_sa = 0, m_ca = 0, m_mk = 0, m_pb = 0, m_cb = 0;
   bit m_ia = 0, m_ib = 0;

   always #5 clk = ~clk;

   dual_interval_timer #(.ADDR_W(AW), .DATA_W(DW)) i_dual_interval_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_b(ack_b), .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_read(input int a);
      case (a)
         0: return m_sa;
         1: return m_ca;
         2: return m_mk;
         default: return m_pb;
      endcase
   endfunction

   function automatic string read_req(input int a);
      case (a)
         0: return "R2";
         1: return "R5";
         2: return "R6";
         default: return "R7";
      endcase
   endfunction

   // advance the reference by one clock edge
   task automatic model_step(input bit en, input bit we, input int a, input int wd,
                             input bit tk, input bit ak);
      bit wrap;
      int nb;
      if (en && we && a == 0) begin
         m_sa = wd; m_ca = wd;
      end else if (en && a == 1) begin
         m_ca = m_sa; m_ia = 0;
      end else if (tk && m_sa != 0 && m_ca > 0 && m_mk[1]) begin
         m_ca = m_ca - 2;
         if (m_ca <= 0) m_ia = 1;
      end
      if (en && we && a == 2) m_mk = wd;
      wrap = 0;
      if (en && we && a == 3) begin
         m_pb = wd; m_cb = wd;
      end else if (tk && m_pb != 0) begin
         nb = m_cb - 5;
         if (nb < 1) begin m_cb = m_pb; wrap = 1; end
         else m_cb = nb;
      end
      if (wrap) m_ib = 1;
      else if (ak) m_ib = 0;
   endtask

   // one bus cycle: drive at negedge, check read data, clock, update model
   task automatic cyc(input bit en, input bit we, input int a, input int wd,
                      input bit tk, input bit ak);
      @(negedge clk);
      chk("R4", {31'd0, irq_a}, {31'd0, m_ia});
      chk("R8", {31'd0, irq_b}, {31'd0, m_ib});
      bus_en = en; bus_we = we; bus_addr = AW'(a); bus_wdata = wd;
      tick = tk; ack_b = ak;
      #1;
      if (en && !we) chk(read_req(a), bus_rdata, exp_read(a));
      else chk("R1", bus_rdata, '0);
      @(posedge clk);
      model_step(en, we, a, wd, tk, ak);
   endtask

   task automatic idle(input bit tk); cyc(0, 0, 0, 0, tk, 0); endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(20240611);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         bus_en = 1; bus_we = 0; bus_addr = AW'(a); #1;
         chk("R1", bus_rdata, '0);
      end
      @(negedge clk) bus_en = 0;
      chk("R1", {30'd0, irq_a, irq_b}, '0);

      // R3: gate closed, count holds
      cyc(1, 1, 0, 6, 0, 0);
      cyc(1, 1, 2, 0, 0, 0);
      idle(1); idle(1);
      @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = 1; #1;
      chk("R3", bus_rdata, 6);
      @(negedge clk); bus_en = 0;
      cyc(1, 1, 2, 2, 0, 0);
      idle(1);
      cyc(1, 0, 1, 0, 0, 0);          // status read: 4, then reload
      // R4: 6 -> 4 -> 2 -> 0 raises irq
      idle(1); idle(1); idle(1);
      @(negedge clk); chk("R4", {31'd0, irq_a}, 1);
      // R3: count at zero stops moving
      idle(1);
      cyc(1, 0, 1, 0, 1, 0);          // status read with tick: reads 0, tick ignored
      @(negedge clk); chk("R5", {31'd0, irq_a}, 0);
      // R5: status write also clears and reloads
      idle(1); idle(1); idle(1);
      cyc(1, 1, 1, 32'h55, 0, 0);
      @(negedge clk); chk("R5", {31'd0, irq_a}, 0);
      cyc(1, 0, 1, 0, 0, 0);
      // R7/R8: period 12: 12 -> 7 -> 2 -> wrap
      cyc(1, 1, 3, 12, 0, 0);
      idle(1); idle(1); idle(1);
      @(negedge clk); chk("R8", {31'd0, irq_b}, 1);
      // R9: ack together with a wrap keeps irq set
      cyc(0, 0, 0, 0, 0, 1);
      @(negedge clk); chk("R9", {31'd0, irq_b}, 0);
      cyc(1, 1, 3, 3, 0, 0);           // period 3: next tick wraps
      cyc(0, 0, 0, 0, 1, 1);
      @(negedge clk); chk("R9", {31'd0, irq_b}, 1);
      cyc(0, 0, 0, 0, 0, 1);
      // R10: period write in a tick cycle wins
      cyc(1, 1, 3, 1, 1, 0);
      @(negedge clk); chk("R10", {31'd0, irq_b}, 0);
      cyc(1, 1, 3, 0, 0, 0);           // period 0 stops counter B
      idle(1); idle(1);
      @(negedge clk); chk("R7", {31'd0, irq_b}, 0);
      // R2: reload write during tick wins
      cyc(1, 1, 2, 2, 0, 0);
      cyc(1, 1, 0, 9, 1, 0);
      cyc(1, 0, 1, 0, 0, 0);
      @(negedge clk); chk("R2", {31'd0, irq_a}, 0);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         int r, a, wd;
         bit en, we, tk, ak;
         r  = $urandom_range(0, 99);
         en = (r < 30);
         we = $urandom_range(0, 1);
         a  = $urandom_range(0, 3);
         wd = $urandom_range(0, 48) - 8;
         if (a == 2) wd = $urandom_range(0, 7);
         tk = ($urandom_range(0, 99) < 55);
         ak = ($urandom_range(0, 99) < 15);
         cyc(en, we, a, wd, tk, ak);
      end
      @(negedge clk);
      chk("R4", {31'd0, irq_a}, {31'd0, m_ia});
      chk("R8", {31'd0, irq_b}, {31'd0, m_ib});
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule